// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output compare channel of a microcontroller timer. It holds a compare value written by software one byte at a time and watches a shared free-running counter that lives outside the block. The counter advances once every fourth bus cycle and announces each step with a one-cycle tick strobe. The channel evaluates equality only in that tick cycle. On a hit it drives a preloaded level onto its compare pin, sets a status flag and, when enabled, raises an interrupt request.

Software produces a pulse by loading a compare value and a level, waiting for the hit, and then loading the old value plus a width together with the opposite level. The pin edges are timed by the counter rather than by software, so the pulse width is exact to one counter step whatever the response latency. At a 1 MHz bus clock one step is 4 us, so a width of 250 (0xFA) gives 1 ms.

Top module: `ocmp_channel`

## Requirements
- R1: After reset the pin, the flag, the interrupt request, the level bit and the interrupt enable are all 0, the compare value reads 0xFFFF, and matching is armed.
- R2: A high-byte write loads bits 15:8 of the compare value and a low-byte write loads bits 7:0. Each write affects only its own byte, and `cmp_o` shows the new value on the cycle after the write.
- R3: A match is taken only in a cycle where `cnt_tick_i` is 1 and `cnt_i` equals the compare value. Its effects appear on the outputs one clock later. An equal count without a tick, or a tick with an unequal count, has no effect.
- R4: On a match the pin takes the level bit (0 drives it low, 1 drives it high). Between matches the pin keeps its last level.
- R5: A match sets the flag, and the flag stays set until it is cleared.
- R6: A one-cycle `flag_clr_i` strobe clears the flag on the next clock. If a match falls in the same cycle, the flag stays set.
- R7: `irq_o` is 1 exactly when the flag and the interrupt enable are both 1.
- R8: A high-byte write without a low-byte write disarms matching. No match is taken, even on an equal count, until the low byte has been written.
- R9: If the compare value is reloaded to old value plus W (modulo 2^16) with the opposite level after a hit, the pin stays at the active level for exactly W counter steps. This holds across counter wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 16 | Shared free-running counter value |
| cnt_tick_i | input | 1 | One-cycle strobe; the counter value is evaluated in this cycle |
| wr_hi_i | input | 1 | Write `wr_data_i` to the high compare byte |
| wr_lo_i | input | 1 | Write `wr_data_i` to the low compare byte |
| wr_data_i | input | 8 | Byte write data |
| lvl_wr_i | input | 1 | Load the output level bit |
| lvl_i | input | 1 | New output level |
| ie_wr_i | input | 1 | Load the interrupt enable bit |
| ie_i | input | 1 | New interrupt enable |
| flag_clr_i | input | 1 | One-cycle flag clear strobe |
| cmp_o | output | 16 | Current compare value |
| pin_o | output | 1 | Compare output pin |
| flag_o | output | 1 | Output compare status flag |
| irq_o | output | 1 | Timer interrupt request |

## Verification
A wrong arm bit would show up as a hit that comes one write too early or never comes at all. Either error is visible on `flag_o` and `pin_o` one clock after the tick concerned. A compare byte lane that takes the wrong byte shows up on `cmp_o` on the cycle after the write, long before any match depends on it. Faults in tick gating or pin update show up as pulse widths that are off by whole counter steps. The width sweeps measure the pulse at every step, including pulses that cross the counter wraparound.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int OCMP_CNT_W = 16;

  typedef struct packed {
    logic level;
    logic irq_en;
  } ocmp_ctl_t;
endpackage

// File: rtl/ocmp_cmp_reg.sv
module ocmp_cmp_reg #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_VAL = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_hi_i,
  input  logic                  wr_lo_i,
  input  logic [CNT_W/2-1:0]    wr_data_i,
  output logic [CNT_W-1:0]      cmp_o,
  output logic                  armed_o
);
  localparam int BYTE_W = CNT_W / 2;
  localparam int LANES  = 2;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic              we;
    logic [BYTE_W-1:0] lane_q;
    assign we = (lane == LANES - 1) ? wr_hi_i : wr_lo_i;
    always_ff @(posedge clk) begin
      if (!rst_n)  lane_q <= RESET_VAL[lane*BYTE_W +: BYTE_W];
      else if (we) lane_q <= wr_data_i;
    end
    assign cmp_o[lane*BYTE_W +: BYTE_W] = lane_q;
  end

  logic armed_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       armed_q <= 1'b1;
    else if (wr_lo_i) armed_q <= 1'b1;
    else if (wr_hi_i) armed_q <= 1'b0;
  end
  assign armed_o = armed_q;

  AST_HI_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_i && !wr_lo_i) |=> !armed_o); // R8
  AST_LO_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> armed_o); // R8
  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i && !wr_hi_i) |=> $stable(cmp_o[CNT_W-1:BYTE_W])); // R2
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             armed_i,
  output logic             match_o
);
  function automatic logic hit_now(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] cmp,
                                   input logic armed, input logic tick);
    return tick && armed && (cnt == cmp);
  endfunction

  assign match_o = hit_now(cnt_i, cmp_i, armed_i, tick_i);
endmodule

// File: rtl/ocmp_ctrl.sv
module ocmp_ctrl
  import ocmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl_wr_i,
  input  logic      lvl_i,
  input  logic      ie_wr_i,
  input  logic      ie_i,
  output ocmp_ctl_t ctl_o
);
  ocmp_ctl_t ctl_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (lvl_wr_i) ctl_q.level  <= lvl_i;
      if (ie_wr_i)  ctl_q.irq_en <= ie_i;
    end
  end
  assign ctl_o = ctl_q;
endmodule

// File: rtl/ocmp_out.sv
module ocmp_out (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic level_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic pin_o,
  output logic flag_o,
  output logic irq_o
);
  logic pin_q, flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pin_q <= 1'b0;
    else if (match_i) pin_q <= level_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (match_i) flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign pin_o  = pin_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;

  AST_PIN_TAKES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    match_i |=> (pin_o == $past(level_i))); // R4
  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !match_i |=> $stable(pin_o)); // R4
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match_i |=> flag_o); // R5
  AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !match_i) |=> !flag_o); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o); // R5
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int CNT_W = OCMP_CNT_W,
  parameter logic [CNT_W-1:0] CMP_RESET = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               cnt_tick_i,
  input  logic               wr_hi_i,
  input  logic               wr_lo_i,
  input  logic [CNT_W/2-1:0] wr_data_i,
  input  logic               lvl_wr_i,
  input  logic               lvl_i,
  input  logic               ie_wr_i,
  input  logic               ie_i,
  input  logic               flag_clr_i,
  output logic [CNT_W-1:0]   cmp_o,
  output logic               pin_o,
  output logic               flag_o,
  output logic               irq_o
);
  logic [CNT_W-1:0] cmp_w;
  logic             armed_w;
  logic             match_w;
  ocmp_ctl_t        ctl_w;

  ocmp_cmp_reg #(.CNT_W(CNT_W), .RESET_VAL(CMP_RESET)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i),
    .wr_data_i(wr_data_i), .cmp_o(cmp_w), .armed_o(armed_w));

  ocmp_match #(.CNT_W(CNT_W)) u_match (
    .cnt_i(cnt_i), .tick_i(cnt_tick_i), .cmp_i(cmp_w),
    .armed_i(armed_w), .match_o(match_w));

  ocmp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .lvl_wr_i(lvl_wr_i), .lvl_i(lvl_i),
    .ie_wr_i(ie_wr_i), .ie_i(ie_i), .ctl_o(ctl_w));

  ocmp_out u_out (
    .clk(clk), .rst_n(rst_n), .match_i(match_w), .level_i(ctl_w.level),
    .clr_i(flag_clr_i), .ie_i(ctl_w.irq_en), .pin_o(pin_o),
    .flag_o(flag_o), .irq_o(irq_o));

  assign cmp_o = cmp_w;

  AST_MATCH_ON_TICK_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    match_w |-> (cnt_tick_i && (cnt_i == cmp_o))); // R3
  AST_NO_TICK_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick_i |=> ($stable(pin_o) && (flag_o || !$rose(flag_o)))); // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o); // R7
endmodule

// File: tb/ocmp_channel_tb.sv
`timescale 1ns/1ps
module ocmp_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        tick = 1'b0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0;
  logic [7:0]  wdat = '0;
  logic        lvl_wr = 1'b0, lvl = 1'b0, ie_wr = 1'b0, ie = 1'b0, clr = 1'b0;
  logic [15:0] cmp;
  logic        pin, flag, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ocmp_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_tick_i(tick),
    .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wr_data_i(wdat),
    .lvl_wr_i(lvl_wr), .lvl_i(lvl), .ie_wr_i(ie_wr), .ie_i(ie),
    .flag_clr_i(clr), .cmp_o(cmp), .pin_o(pin), .flag_o(flag), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input bit hi, input logic [7:0] d);
    @(negedge clk); wdat = d; wr_hi = hi; wr_lo = !hi;
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic wr_cmp(input logic [15:0] v);
    wr_byte(1'b1, v[15:8]);
    wr_byte(1'b0, v[7:0]);
  endtask

  task automatic set_lvl(input logic b);
    @(negedge clk); lvl = b; lvl_wr = 1'b1;
    @(negedge clk); lvl_wr = 1'b0;
  endtask

  task automatic set_ie(input logic b);
    @(negedge clk); ie = b; ie_wr = 1'b1;
    @(negedge clk); ie_wr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // one counter step: tick for one bus cycle, then three quiet cycles
  task automatic tick_once(input logic [15:0] v);
    @(negedge clk); cnt = v; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // measure active-high pulse width produced by reprogramming after the hit
  task automatic run_pulse(input logic [15:0] base, input int w);
    logic [15:0] c;
    int high;
    int phase;
    logic [15:0] prep;
    prep = base - 16'd5;
    wr_cmp(prep); set_lvl(1'b0); tick_once(prep);
    check("R4 pulse idle low", pin, 0);
    wr_cmp(base); set_lvl(1'b1); clear_flag();
    c = base - 16'd2; high = 0; phase = 0;
    for (int k = 0; k < w + 8; k++) begin
      tick_once(c);
      if (phase == 0 && pin) begin
        phase = 1; high = 1;
        wr_cmp(base + w[15:0]); set_lvl(1'b0);
      end else if (phase == 1) begin
        if (pin) high++;
        else phase = 2;
      end
      c = c + 16'd1;
    end
    check("R9 pulse width", high, w);
    check("R9 pulse ended low", pin, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin", pin, 0);
    check("R1 flag", flag, 0);
    check("R1 irq", irq, 0);
    check("R1 cmp", cmp, 16'hFFFF);
    // R1: armed at reset, level 0 -> tick at FFFF sets flag, pin stays 0
    tick_once(16'hFFFF);
    check("R1 armed flag", flag, 1);
    check("R1 level zero pin", pin, 0);
    check("R7 irq disabled", irq, 0);
    clear_flag();
    check("R6 clear", flag, 0);

    // R2 byte writes
    wr_byte(1'b1, 8'h12);
    check("R2 hi byte only", cmp, 16'h12FF);
    wr_byte(1'b0, 8'h34);
    check("R2 lo byte", cmp, 16'h1234);

    // R3 gating
    set_lvl(1'b1);
    @(negedge clk); cnt = 16'h1234; tick = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 no tick no flag", flag, 0);
    check("R3 no tick no pin", pin, 0);
    tick_once(16'h1235);
    check("R3 unequal no flag", flag, 0);
    @(negedge clk); cnt = 16'h1234; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R3 one cycle later pin", pin, 1);
    check("R5 flag set", flag, 1);
    repeat (6) @(negedge clk);
    check("R4 pin holds", pin, 1);
    check("R5 flag holds", flag, 1);

    // R7 interrupt
    set_ie(1'b1);
    check("R7 irq on", irq, 1);
    clear_flag();
    check("R7 irq off after clear", irq, 0);

    // R6 match beats clear
    @(negedge clk); cnt = 16'h1234; tick = 1'b1; clr = 1'b1;
    @(negedge clk); tick = 1'b0; clr = 1'b0;
    check("R6 match wins over clear", flag, 1);
    clear_flag();

    // R4 level 0 drives low
    set_lvl(1'b0);
    tick_once(16'h1234);
    check("R4 drive low", pin, 0);
    clear_flag();

    // R8 arming
    set_lvl(1'b1);
    wr_byte(1'b1, 8'h20);
    check("R8 cmp half updated", cmp, 16'h2034);
    tick_once(16'h2034);
    check("R8 disarmed no flag", flag, 0);
    check("R8 disarmed no pin", pin, 0);
    tick_once(16'h1234);
    check("R8 old value no match", flag, 0);
    wr_byte(1'b0, 8'h34);
    tick_once(16'h2034);
    check("R8 rearmed flag", flag, 1);
    check("R8 rearmed pin", pin, 1);
    clear_flag();
    set_ie(1'b0);

    // R9 pulse sweeps, including wraparound
    for (int w = 1; w <= 20; w++) run_pulse(16'h0100, w);
    for (int w = 1; w <= 20; w++) run_pulse(16'hFFF4, w);
    run_pulse(16'h8000, 250);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule